// File: doc/BRIEF.md
# Multi-Cycle Integer RISC Core

This block is an unpipelined integer processor for a small load-store instruction subset. Every instruction walks through up to five steps (fetch, decode, execute, memory, write-back). Each step keeps its results in holding registers: the fetched word, the next sequential PC, the two source operands, the sign-extended immediate, the execute result and the memory-step result. Stores, branches and jumps end after the memory step. Loads and ALU operations also take the write-back step, so instruction classes differ in cycle count.

The core has a 32-entry register file in which register 0 is fixed at zero. It has a word-organised instruction memory and a data memory, both byte-addressed by the core with word-aligned accesses. A host port on each memory lets a testbench preload a program and data while reset is held, and read the memories back afterwards. A debug read port shows any register. An opcode or function code outside the subset stops the core in a halt state that raises a flag. A pulse marks the last cycle of each completed instruction.

Top module: `mc_risc_core`

## Requirements
- R1: Instruction fields are: opcode in bits [31:26], first source in [25:21] (read into operand A), second source in [20:16] (read into operand B, and the destination of immediate-form, load instructions), register-form destination in [15:11], function code in [5:0], 16-bit immediate in [15:0], and 26-bit jump displacement in [25:0]. Both immediates are sign-extended to the register width.
- R2: Opcodes: 0x00 register-form ALU, 0x08 add-immediate, 0x0A set-less-than-immediate, 0x0C and-immediate, 0x0D or-immediate, 0x23 load word, 0x2B store word, 0x04 branch if A is zero, 0x05 branch if A is non-zero, 0x02 jump, 0x12 jump-register.
- R3: Register-form function codes: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (writes 1 or 0), 0x04 shift left logical and 0x06 shift right logical. Both shifts use the low five bits of B as the shift amount.
- R4: The immediate ALU forms compute A op sign-extended immediate. Set-less-than-immediate compares signed.
- R5: The effective address of a load or store is A plus the sign-extended immediate, as a byte address. The word at address bits [7:2] (default depth) is read into the destination, or receives B.
- R6: A conditional branch tests A against zero. When the branch is taken, the PC becomes NPC plus the immediate (a byte offset, where NPC is the branch address plus 4). Otherwise the PC becomes NPC.
- R7: Jump sets the PC to NPC plus the sign-extended 26-bit displacement. Jump-register sets the PC to NPC plus A.
- R8: Register 0 reads as zero. Writes to it have no effect.
- R9: Loads and ALU instructions take 5 cycles. Stores, branches and jumps take 4. The retire output is high only in the last cycle of each instruction, and the next fetch follows at once.
- R10: An undefined opcode or register-form function code moves the core to halt at the end of the decode cycle. From then on, halted stays high, nothing retires and the PC does not change.
- R11: While rst_n is low, retire and halted are low and the PC is 0. The reset is released through two flops, so the first fetch cycle is the one that begins at the second rising edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_imem_we | input | 1 | Host write strobe, instruction memory |
| host_imem_addr | input | 6 | Host word index, instruction memory |
| host_imem_wdata | input | 32 | Host write word, instruction memory |
| host_imem_rdata | output | 32 | Host read word, instruction memory |
| host_dmem_we | input | 1 | Host write strobe, data memory |
| host_dmem_addr | input | 6 | Host word index, data memory |
| host_dmem_wdata | input | 32 | Host write word, data memory |
| host_dmem_rdata | output | 32 | Host read word, data memory |
| dbg_reg_sel | input | 5 | Register selected for debug read |
| dbg_reg_val | output | 32 | Value of the selected register |
| retire | output | 1 | High in the final cycle of an instruction |
| halted | output | 1 | Core stopped on an undefined instruction |

## Verification
Counted from an instruction's fetch cycle, retire is due in cycle 5 for loads and ALU operations and in cycle 4 for stores, branches and jumps. For an undefined instruction, halted is due in cycle 3. The bench keeps a behavioural instruction-level model that counts cycles in the same way. On every falling edge it compares retire and halted with the model. It updates the model's registers and memory only in the cycle where retire is expected. After the halt, it reads every register through the debug port and every data word through the host port, compares each with the model, and checks a set of hand-computed results for sums, shifts, signed compares, skipped instructions and register 0.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [2:0] {ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB, ST_HALT} step_e;

  typedef enum logic [2:0] {
    K_ALU_R, K_ALU_I, K_LOAD, K_STORE, K_BRZ, K_BRNZ, K_JUMP, K_JREG
  } kind_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT, OP_SLL, OP_SRL
  } alu_op_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e op;
    logic    legal;
    logic    writes;
  } dec_t;

  localparam logic [5:0] OPC_RALU = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;
  localparam logic [5:0] OPC_BZ   = 6'h04;
  localparam logic [5:0] OPC_BNZ  = 6'h05;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_JR   = 6'h12;

  function automatic dec_t decode_op(input logic [5:0] opc, input logic [5:0] fn);
    dec_t d;
    d = '{kind: K_ALU_I, op: OP_ADD, legal: 1'b1, writes: 1'b1};
    case (opc)
      OPC_RALU: begin
        d.kind = K_ALU_R;
        case (fn)
          6'h20: d.op = OP_ADD;
          6'h22: d.op = OP_SUB;
          6'h24: d.op = OP_AND;
          6'h25: d.op = OP_OR;
          6'h2A: d.op = OP_SLT;
          6'h04: d.op = OP_SLL;
          6'h06: d.op = OP_SRL;
          default: d.legal = 1'b0;
        endcase
      end
      OPC_ADDI: d.op = OP_ADD;
      OPC_SLTI: d.op = OP_SLT;
      OPC_ANDI: d.op = OP_AND;
      OPC_ORI:  d.op = OP_OR;
      OPC_LW:   d.kind = K_LOAD;
      OPC_SW:   begin d.kind = K_STORE; d.writes = 1'b0; end
      OPC_BZ:   begin d.kind = K_BRZ;   d.writes = 1'b0; end
      OPC_BNZ:  begin d.kind = K_BRNZ;  d.writes = 1'b0; end
      OPC_J:    begin d.kind = K_JUMP;  d.writes = 1'b0; end
      OPC_JR:   begin d.kind = K_JREG;  d.writes = 1'b0; end
      default:  begin d.legal = 1'b0;   d.writes = 1'b0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mcr_alu.sv
module mcr_alu
  import mcr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res
);
  localparam int SHW = $clog2(XLEN);

  always_comb begin
    case (op)
      OP_SUB:  res = x - y;
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_SLT:  res = ($signed(x) < $signed(y)) ? XLEN'(1) : '0;
      OP_SLL:  res = x << y[SHW-1:0];
      OP_SRL:  res = x >> y[SHW-1:0];
      default: res = x + y;
    endcase
  end
endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  input  logic [$clog2(NREG)-1:0] rd,
  output logic [XLEN-1:0]         qa,
  output logic [XLEN-1:0]         qb,
  output logic [XLEN-1:0]         qd
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic            en;
    logic [XLEN-1:0] q;
    assign en = we && (waddr == i);
    always_ff @(posedge clk) begin
      if (en) q <= wdata;
    end
    assign regs[i] = q;
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
  assign qd = regs[rd];
endmodule

// File: rtl/mcr_mem.sv
module mcr_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     a_we,
  input  logic [$clog2(DEPTH)-1:0] a_addr,
  input  logic [W-1:0]             a_wdata,
  output logic [W-1:0]             a_rdata,
  input  logic                     b_we,
  input  logic [$clog2(DEPTH)-1:0] b_addr,
  input  logic [W-1:0]             b_wdata,
  output logic [W-1:0]             b_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we)      mem[a_addr] <= a_wdata;
    else if (b_we) mem[b_addr] <= b_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
  import mcr_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_imem_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] host_imem_addr,
  input  logic [31:0]                   host_imem_wdata,
  output logic [31:0]                   host_imem_rdata,
  input  logic                          host_dmem_we,
  input  logic [$clog2(DMEM_WORDS)-1:0] host_dmem_addr,
  input  logic [XLEN-1:0]               host_dmem_wdata,
  output logic [XLEN-1:0]               host_dmem_rdata,
  input  logic [4:0]                    dbg_reg_sel,
  output logic [XLEN-1:0]               dbg_reg_val,
  output logic                          retire,
  output logic                          halted
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  step_e           state_q, state_d;
  logic [XLEN-1:0] pc_q, pc_d, npc_q, npc_d, a_q, a_d, b_q, b_d;
  logic [XLEN-1:0] imm_q, imm_d, aluout_q, aluout_d, lmd_q, lmd_d;
  logic [31:0]     ir_q, ir_d;
  logic            cond_q, cond_d;

  logic [31:0]     imem_rdata;
  logic [XLEN-1:0] dmem_rdata, rf_a, rf_b, alu_x, alu_y, alu_res;
  logic            dmem_we, rf_we;
  logic [4:0]      dest;
  alu_op_e         alu_op;
  dec_t            dec;

  assign dec  = decode_op(ir_q[31:26], ir_q[5:0]);
  assign dest = (dec.kind == K_ALU_R) ? ir_q[15:11] : ir_q[20:16];

  mcr_mem #(.W(32), .DEPTH(IMEM_WORDS)) u_imem (
    .clk(clk), .a_we(1'b0), .a_addr(pc_q[IAW+1:2]), .a_wdata('0),
    .a_rdata(imem_rdata), .b_we(host_imem_we), .b_addr(host_imem_addr),
    .b_wdata(host_imem_wdata), .b_rdata(host_imem_rdata));

  mcr_mem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk(clk), .a_we(dmem_we), .a_addr(aluout_q[DAW+1:2]), .a_wdata(b_q),
    .a_rdata(dmem_rdata), .b_we(host_dmem_we), .b_addr(host_dmem_addr),
    .b_wdata(host_dmem_wdata), .b_rdata(host_dmem_rdata));

  mcr_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
    .clk(clk), .we(rf_we), .waddr(dest), .wdata(lmd_q),
    .ra(ir_q[25:21]), .rb(ir_q[20:16]), .rd(dbg_reg_sel),
    .qa(rf_a), .qb(rf_b), .qd(dbg_reg_val));

  // one ALU serves operations, addresses and jump targets
  always_comb begin
    alu_x  = a_q;
    alu_y  = imm_q;
    alu_op = OP_ADD;
    case (dec.kind)
      K_ALU_R: begin alu_y = b_q; alu_op = dec.op; end
      K_ALU_I: alu_op = dec.op;
      K_BRZ, K_BRNZ, K_JUMP: alu_x = npc_q;
      K_JREG:  begin alu_x = npc_q; alu_y = a_q; end
      default: ;
    endcase
  end

  mcr_alu #(.XLEN(XLEN)) u_alu (.x(alu_x), .y(alu_y), .op(alu_op), .res(alu_res));

  // next-state process
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    npc_d    = npc_q;
    ir_d     = ir_q;
    a_d      = a_q;
    b_d      = b_q;
    imm_d    = imm_q;
    aluout_d = aluout_q;
    lmd_d    = lmd_q;
    cond_d   = cond_q;
    dmem_we  = 1'b0;
    rf_we    = 1'b0;
    case (state_q)
      ST_IF: begin
        ir_d    = imem_rdata;
        npc_d   = pc_q + XLEN'(4);
        state_d = ST_ID;
      end
      ST_ID: begin
        a_d     = rf_a;
        b_d     = rf_b;
        imm_d   = (dec.kind == K_JUMP) ? {{(XLEN-26){ir_q[25]}}, ir_q[25:0]}
                                       : {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
        state_d = dec.legal ? ST_EX : ST_HALT;
      end
      ST_EX: begin
        aluout_d = alu_res;
        case (dec.kind)
          K_BRZ:          cond_d = (a_q == '0);
          K_BRNZ:         cond_d = (a_q != '0);
          K_JUMP, K_JREG: cond_d = 1'b1;
          default:        cond_d = 1'b0;
        endcase
        state_d = ST_MEM;
      end
      ST_MEM: begin
        lmd_d   = (dec.kind == K_LOAD) ? dmem_rdata : aluout_q;
        dmem_we = (dec.kind == K_STORE);
        pc_d    = cond_q ? aluout_q : npc_q;
        state_d = dec.writes ? ST_WB : ST_IF;
      end
      ST_WB: begin
        rf_we   = 1'b1;
        state_d = ST_IF;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= ST_IF;
      pc_q     <= '0;
      npc_q    <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      imm_q    <= '0;
      aluout_q <= '0;
      lmd_q    <= '0;
      cond_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      npc_q    <= npc_d;
      ir_q     <= ir_d;
      a_q      <= a_d;
      b_q      <= b_d;
      imm_q    <= imm_d;
      aluout_q <= aluout_d;
      lmd_q    <= lmd_d;
      cond_q   <= cond_d;
    end
  end

  assign retire = (state_q == ST_WB) || ((state_q == ST_MEM) && !dec.writes);
  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/mcr_core_chk.sv
module mcr_core_chk
  import mcr_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input step_e        state,
  input logic [W-1:0] pc,
  input logic         retire,
  input logic         halted
);
  // R9: an instruction retires for a single cycle and a fetch follows
  a_r9_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
  a_r9_fetch_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (state == ST_IF));
  // R6: the PC is only loaded in the memory step
  a_r6_pc_update_in_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_MEM) |=> $stable(pc));
  // R10: halt is sticky, freezes the PC and stops retirement
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));
  a_r10_no_retire_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !retire);
endmodule

bind mc_risc_core mcr_core_chk #(.W(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_q), .state(state_q), .pc(pc_q),
  .retire(retire), .halted(halted));

// File: tb/sim_mc_risc_core.sv
module sim_mc_risc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_imem_we, host_dmem_we;
  logic [5:0]  host_imem_addr, host_dmem_addr;
  logic [31:0] host_imem_wdata, host_imem_rdata, host_dmem_wdata, host_dmem_rdata;
  logic [4:0]  dbg_reg_sel;
  logic [31:0] dbg_reg_val;
  logic        retire, halted;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mc_risc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .host_imem_we(host_imem_we), .host_imem_addr(host_imem_addr),
    .host_imem_wdata(host_imem_wdata), .host_imem_rdata(host_imem_rdata),
    .host_dmem_we(host_dmem_we), .host_dmem_addr(host_dmem_addr),
    .host_dmem_wdata(host_dmem_wdata), .host_dmem_rdata(host_dmem_rdata),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .retire(retire), .halted(halted));

  logic [31:0] prog [64];
  logic [31:0] mr [32];
  logic [31:0] md [64];
  logic [31:0] mpc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int fn, input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int rt, input int rs, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(input int op, input int off);
    return {op[5:0], off[25:0]};
  endfunction

  // cycles an instruction takes, 0 when undefined (R2, R3, R9)
  function automatic int ilen(input logic [31:0] w);
    case (w[31:26])
      6'h00: return (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h04, 6'h06}) ? 5 : 0;
      6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h23: return 5;
      6'h2B, 6'h04, 6'h05, 6'h02, 6'h12: return 4;
      default: return 0;
    endcase
  endfunction

  // instruction-level reference
  task automatic model_exec(input logic [31:0] w);
    logic [31:0] a, b, imm, npc, nxt, val;
    int dst;
    bit wr;
    a   = mr[w[25:21]];
    b   = mr[w[20:16]];
    imm = {{16{w[15]}}, w[15:0]};
    npc = mpc + 4;
    nxt = npc;
    wr  = 1'b1;
    dst = w[20:16];
    val = 0;
    case (w[31:26])
      6'h00: begin
        dst = w[15:11];
        case (w[5:0])
          6'h20: val = a + b;
          6'h22: val = a - b;
          6'h24: val = a & b;
          6'h25: val = a | b;
          6'h2A: val = ($signed(a) < $signed(b)) ? 1 : 0;
          6'h04: val = a << b[4:0];
          default: val = a >> b[4:0];
        endcase
      end
      6'h08: val = a + imm;
      6'h0A: val = ($signed(a) < $signed(imm)) ? 1 : 0;
      6'h0C: val = a & imm;
      6'h0D: val = a | imm;
      6'h23: val = md[(a + imm) >> 2 & 63];
      6'h2B: begin wr = 1'b0; md[(a + imm) >> 2 & 63] = b; end
      6'h04: begin wr = 1'b0; if (a == 0) nxt = npc + imm; end
      6'h05: begin wr = 1'b0; if (a != 0) nxt = npc + imm; end
      6'h02: begin wr = 1'b0; nxt = npc + {{6{w[25]}}, w[25:0]}; end
      default: begin wr = 1'b0; nxt = npc + a; end
    endcase
    if (wr && dst != 0) mr[dst] = val;
    mpc = nxt;
  endtask

  initial begin
    int cyc, hcnt, wd, len;
    logic [31:0] w;
    rst_n = 1'b0;
    host_imem_we = 0; host_dmem_we = 0;
    host_imem_addr = 0; host_dmem_addr = 0;
    host_imem_wdata = 0; host_dmem_wdata = 0;
    dbg_reg_sel = 0;

    for (int i = 0; i < 64; i++) prog[i] = 32'hFC00_0000;
    prog[0]  = enc_i(8'h23, 3, 0, 80);
    prog[1]  = enc_i(8'h08, 1, 0, 0);
    prog[2]  = enc_i(8'h08, 2, 0, 0);
    prog[3]  = enc_i(8'h04, 0, 3, 20);
    prog[4]  = enc_i(8'h23, 4, 1, 0);
    prog[5]  = enc_r(8'h20, 2, 2, 4);
    prog[6]  = enc_i(8'h08, 1, 1, 4);
    prog[7]  = enc_i(8'h08, 3, 3, -1);
    prog[8]  = enc_j(8'h02, -24);
    prog[9]  = enc_i(8'h2B, 2, 0, 84);
    prog[10] = enc_r(8'h22, 5, 0, 2);
    prog[11] = enc_r(8'h2A, 6, 5, 2);
    prog[12] = enc_r(8'h2A, 7, 2, 5);
    prog[13] = enc_i(8'h0C, 8, 2, 255);
    prog[14] = enc_i(8'h0D, 9, 0, -16);
    prog[15] = enc_r(8'h25, 10, 8, 9);
    prog[16] = enc_i(8'h0A, 11, 5, -1);
    prog[17] = enc_i(8'h08, 12, 0, 3);
    prog[18] = enc_r(8'h04, 13, 9, 12);
    prog[19] = enc_r(8'h06, 14, 9, 12);
    prog[20] = enc_i(8'h08, 0, 0, 55);
    prog[21] = enc_i(8'h2B, 0, 0, 88);
    prog[22] = enc_i(8'h05, 0, 12, 4);
    prog[23] = enc_i(8'h08, 15, 0, 1);
    prog[24] = enc_i(8'h08, 16, 0, 2);
    prog[25] = enc_i(8'h05, 0, 0, 4);
    prog[26] = enc_i(8'h08, 17, 0, 9);
    prog[27] = enc_i(8'h08, 18, 0, 4);
    prog[28] = enc_i(8'h12, 0, 18, 0);
    prog[29] = enc_i(8'h08, 19, 0, 7);
    prog[30] = enc_i(8'h08, 20, 0, 8);

    for (int i = 0; i < 32; i++) mr[i] = 0;
    for (int i = 0; i < 64; i++) md[i] = 0;
    md[0] = 3; md[1] = -7; md[2] = 100; md[3] = 32'h7FFF_0000; md[4] = 12;
    md[20] = 5; md[22] = 32'hDEAD_BEEF;
    mpc = 0;

    // preload both memories while reset holds the core
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      host_imem_we = 1; host_imem_addr = i[5:0]; host_imem_wdata = prog[i];
      host_dmem_we = 1; host_dmem_addr = i[5:0]; host_dmem_wdata = md[i];
    end
    @(negedge clk);
    host_imem_we = 0; host_dmem_we = 0;
    chk(retire == 1'b0, "R11 retire in reset", {31'b0, retire}, 0);
    chk(halted == 1'b0, "R11 halted in reset", {31'b0, halted}, 0);
    host_imem_addr = 6'd5;
    #2 chk(host_imem_rdata == prog[5], "R11 host preload", host_imem_rdata, prog[5]);

    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    cyc = 0; hcnt = 0; wd = 0;
    while (hcnt < 4 && wd < 5000) begin
      @(negedge clk);
      wd++;
      w = prog[mpc[7:2]];
      len = ilen(w);
      cyc++;
      if (len == 0) begin
        chk(halted == (cyc >= 3), "R10 halt timing", {31'b0, halted}, {31'b0, cyc >= 3});
        chk(retire == 1'b0, "R10 no retire", {31'b0, retire}, 0);
        if (cyc >= 3) hcnt++;
      end else begin
        chk(retire == (cyc == len), "R9 retire cycle", {31'b0, retire}, {31'b0, cyc == len});
        chk(halted == 1'b0, "R10 not halted", {31'b0, halted}, 0);
        if (cyc == len) begin
          model_exec(w);
          cyc = 0;
        end
      end
    end
    if (wd >= 5000) chk(1'b0, "R10 watchdog expired", wd, 5000);

    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dbg_reg_sel = i[4:0];
      #2 chk(dbg_reg_val == mr[i], "R1 register vs model", dbg_reg_val, mr[i]);
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      host_dmem_addr = i[5:0];
      #2 chk(host_dmem_rdata == md[i], "R5 data word vs model", host_dmem_rdata, md[i]);
    end

    // hand-computed results
    @(negedge clk); host_dmem_addr = 6'd21;
    #2 chk(host_dmem_rdata == 32'h7FFF_006C, "R5 stored array sum", host_dmem_rdata, 32'h7FFF_006C);
    host_dmem_addr = 6'd22;
    #2 chk(host_dmem_rdata == 0, "R8 store of r0", host_dmem_rdata, 0);
    dbg_reg_sel = 0;
    #2 chk(dbg_reg_val == 0, "R8 r0 after write", dbg_reg_val, 0);
    dbg_reg_sel = 6;
    #2 chk(dbg_reg_val == 1, "R3 signed slt true", dbg_reg_val, 1);
    dbg_reg_sel = 7;
    #2 chk(dbg_reg_val == 0, "R3 signed slt false", dbg_reg_val, 0);
    dbg_reg_sel = 10;
    #2 chk(dbg_reg_val == 32'hFFFF_FFFC, "R4 or of sign-extended immediate", dbg_reg_val, 32'hFFFF_FFFC);
    dbg_reg_sel = 11;
    #2 chk(dbg_reg_val == 1, "R4 slti signed", dbg_reg_val, 1);
    dbg_reg_sel = 13;
    #2 chk(dbg_reg_val == 32'hFFFF_FF80, "R3 sll", dbg_reg_val, 32'hFFFF_FF80);
    dbg_reg_sel = 14;
    #2 chk(dbg_reg_val == 32'h1FFF_FFFE, "R3 srl", dbg_reg_val, 32'h1FFF_FFFE);
    dbg_reg_sel = 15;
    #2 chk(dbg_reg_val == 0, "R6 taken branch skips", dbg_reg_val, 0);
    dbg_reg_sel = 17;
    #2 chk(dbg_reg_val == 9, "R6 untaken branch falls through", dbg_reg_val, 9);
    dbg_reg_sel = 19;
    #2 chk(dbg_reg_val == 0, "R7 jump-register skips", dbg_reg_val, 0);
    dbg_reg_sel = 20;
    #2 chk(dbg_reg_val == 8, "R7 jump-register target", dbg_reg_val, 8);
    dbg_reg_sel = 3;
    #2 chk(dbg_reg_val == 0, "R2 loop counter exhausted", dbg_reg_val, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule